// File: doc/BRIEF.md
# Two-Mode Receiver Automatic Gain Control

This block sets the gain of a receiver's variable-gain amplifier from the energy of the complex baseband samples it sees. Each symbol period it adds up I squared plus Q squared over every accepted sample, cyclic guard included. The symbol ends on the sample that carries `s_last`. At start-up the block waits in a detect mode until a signal shows up. It then makes one large gain correction and freezes the gain while the synchronization logic trains. After that it enters a tracking mode that only adjusts the low-order gain field, and only on preamble symbols.

The gain code feeds two amplifier stages. The upper `GAIN_W-FINE_W` bits drive the coarse stage and the low `FINE_W` bits drive the fine stage. The energy target is the power of two `2**TARGET_EXP`. The coarse correction works in octaves of energy: the leading-one position of the measured energy is compared with `TARGET_EXP`, and each octave of difference is worth `STEPS_PER_OCT` gain codes.

The sample input is a valid/ready stream. The block never applies back-pressure, so `s_ready` is high in every cycle. A beat is transferred on each rising edge where `s_valid` is high. `s_i`, `s_q`, `s_last` and `s_preamble` are ignored in any cycle where `s_valid` is low. `training_done` and `restart` are plain level-sampled controls.

Top module: `agc_top`

## Requirements
- R1: Symbol energy is the sum of `s_i*s_i + s_q*s_q` (signed samples) over the beats transferred since the previous `s_last` beat, up to and including the next one. Beats with `s_valid` low contribute nothing.
- R2: After reset `agc_mode` is 2'b00 (detect) and `gain_code` equals `GAIN_INIT`. The only legal mode codes are 00 detect, 01 hold and 10 fine.
- R3: In detect mode, a symbol whose energy is strictly above `DET_THR` increments a run count. A symbol at or below `DET_THR` clears it. The block leaves detect mode only on the `DET_COUNT`-th consecutive symbol above the threshold.
- R4: On that symbol the gain becomes the current gain plus `(TARGET_EXP - m) * STEPS_PER_OCT`, where m is the bit index of the energy's highest set bit. The result is clamped to 0 .. `2**GAIN_W-1`. The mode becomes hold. Both outputs update by the second rising edge after the `s_last` beat is accepted.
- R5: In hold mode `gain_code` does not change, whatever symbols arrive.
- R6: `training_done` high in hold mode moves the block to fine mode. In detect or fine mode it has no effect.
- R7: In fine mode, a preamble symbol (`s_preamble` high on its `s_last` beat) with energy strictly below `2**TARGET_EXP - HYST` adds one to the low `FINE_W` bits, saturating at all ones. The upper gain bits never change in fine mode.
- R8: In fine mode, a preamble symbol with energy strictly above `2**TARGET_EXP + HYST` subtracts one from the low `FINE_W` bits, saturating at zero.
- R9: In fine mode, gain is unchanged by non-preamble symbols and by preamble symbols whose energy lies within the hysteresis band, band edges included.
- R10: `restart` high in any mode returns the block to detect mode with `GAIN_INIT` on the next edge. It also clears the run count and discards any partly summed symbol.
- R11: `s_ready` is high in every cycle; the block never back-pressures the sample stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat accepted (always high) |
| s_i | input | SAMPLE_W | In-phase sample, signed |
| s_q | input | SAMPLE_W | Quadrature sample, signed |
| s_last | input | 1 | Beat is the last of its symbol |
| s_preamble | input | 1 | Symbol is a preamble (taken on the last beat) |
| training_done | input | 1 | Synchronization training finished |
| restart | input | 1 | Return to signal detection |
| gain_code | output | GAIN_W | Amplifier gain code, coarse field high, fine field low |
| agc_mode | output | 2 | 00 detect, 01 hold, 10 fine |

## Verification
The coarse setting is swept over a wide range of constant-amplitude symbols, in-phase only and mixed I/Q, with symbol lengths from 8 to 32. This covers every octave of the leading-one step and both clamp ends, and separates a wrong leading-one index or step scale from a wrong clamp. Some sweeps insert idle beats carrying large junk values and a false `s_last`, so a design that sums or ends symbols on non-valid beats gives a different gain. The detect run is tried with an at-threshold symbol between two above-threshold ones. Fine tracking is driven with low, high, in-band and exact band-edge preamble energies, plus low non-preamble symbols. This tells apart saturation, a wrong direction, a strict versus inclusive compare, and a preamble qualifier that is missing.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    MODE_DETECT = 2'b00,
    MODE_HOLD   = 2'b01,
    MODE_FINE   = 2'b10
  } agc_mode_e;
endpackage

// File: rtl/agc_energy_acc.sv
module agc_energy_acc #(
  parameter int SAMPLE_W = 8,
  parameter int ENERGY_W = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       take,
  input  logic                       last,
  input  logic                       pre,
  input  logic signed [SAMPLE_W-1:0] i_s,
  input  logic signed [SAMPLE_W-1:0] q_s,
  output logic [ENERGY_W-1:0]        energy,
  output logic                       e_valid,
  output logic                       e_pre
);
  localparam int SQ_W = 2 * SAMPLE_W;

  logic signed [SQ_W-1:0] i_ext, q_ext, i_sq, q_sq;
  logic [ENERGY_W-1:0]    term, acc, acc_next;

  always_comb begin
    i_ext    = {{SAMPLE_W{i_s[SAMPLE_W-1]}}, i_s};
    q_ext    = {{SAMPLE_W{q_s[SAMPLE_W-1]}}, q_s};
    i_sq     = i_ext * i_ext;
    q_sq     = q_ext * q_ext;
    term     = ENERGY_W'(unsigned'(i_sq)) + ENERGY_W'(unsigned'(q_sq));
    acc_next = acc + term;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      energy  <= '0;
      e_valid <= 1'b0;
      e_pre   <= 1'b0;
    end else begin
      e_valid <= 1'b0;
      if (clear) begin
        acc <= '0;
      end else if (take) begin
        if (last) begin
          energy  <= acc_next;
          e_valid <= 1'b1;
          e_pre   <= pre;
          acc     <= '0;
        end else begin
          acc <= acc_next;
        end
      end
    end
  end
endmodule

// File: rtl/agc_msb.sv
module agc_msb #(
  parameter int W     = 26,
  parameter int POS_W = 5
) (
  input  logic [W-1:0]     value,
  output logic [POS_W-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int k = 0; k < W; k++) begin
      if (value[k]) pos = POS_W'(k);
    end
  end
endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int GAIN_W        = 6,
  parameter int FINE_W        = 2,
  parameter int GAIN_INIT     = 32,
  parameter int ENERGY_W      = 26,
  parameter int POS_W         = 5,
  parameter int DET_THR       = 1000,
  parameter int DET_COUNT     = 2,
  parameter int TARGET_EXP    = 14,
  parameter int HYST          = 2048,
  parameter int STEPS_PER_OCT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                e_valid,
  input  logic                e_pre,
  input  logic [ENERGY_W-1:0] energy,
  input  logic [POS_W-1:0]    msb_pos,
  input  logic                training_done,
  input  logic                restart,
  output agc_mode_e           mode,
  output logic [GAIN_W-1:0]   gain
);
  localparam int CNT_W  = $clog2(DET_COUNT + 1);
  localparam int GMAX   = (1 << GAIN_W) - 1;
  localparam int FMAX   = (1 << FINE_W) - 1;
  localparam logic [ENERGY_W-1:0] THR_E  = ENERGY_W'(DET_THR);
  localparam logic [ENERGY_W-1:0] LOW_E  = ENERGY_W'((1 << TARGET_EXP) - HYST);
  localparam logic [ENERGY_W-1:0] HIGH_E = ENERGY_W'((1 << TARGET_EXP) + HYST);

  logic [CNT_W-1:0]    run_cnt;
  logic signed [31:0]  cand;
  logic [GAIN_W-1:0]   coarse_gain;
  logic [FINE_W-1:0]   fine_lo;
  logic                above_thr, run_full;

  always_comb begin
    cand = 32'(int'(gain)) + (32'(TARGET_EXP) - 32'(int'(msb_pos))) * 32'(STEPS_PER_OCT);
    if (cand < 0)            coarse_gain = '0;
    else if (cand > GMAX)    coarse_gain = GAIN_W'(GMAX);
    else                     coarse_gain = cand[GAIN_W-1:0];
    above_thr = energy > THR_E;
    run_full  = run_cnt == CNT_W'(DET_COUNT - 1);
    fine_lo   = gain[FINE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      mode    <= MODE_DETECT;
      gain    <= GAIN_W'(GAIN_INIT);
      run_cnt <= '0;
    end else begin
      unique case (mode)
        MODE_DETECT: begin
          if (e_valid) begin
            if (!above_thr) begin
              run_cnt <= '0;
            end else if (run_full) begin
              run_cnt <= '0;
              gain    <= coarse_gain;
              mode    <= MODE_HOLD;
            end else begin
              run_cnt <= run_cnt + 1'b1;
            end
          end
        end
        MODE_HOLD: begin
          if (training_done) mode <= MODE_FINE;
        end
        MODE_FINE: begin
          if (e_valid && e_pre) begin
            if (energy < LOW_E && fine_lo != FINE_W'(FMAX))
              gain[FINE_W-1:0] <= fine_lo + 1'b1;
            else if (energy > HIGH_E && fine_lo != '0)
              gain[FINE_W-1:0] <= fine_lo - 1'b1;
          end
        end
        default: mode <= MODE_DETECT;
      endcase
    end
  end
endmodule

// File: rtl/agc_top.sv
module agc_top
  import agc_pkg::*;
#(
  parameter int SAMPLE_W      = 8,
  parameter int MAX_SYM_LEN   = 512,
  parameter int GAIN_W        = 6,
  parameter int FINE_W        = 2,
  parameter int GAIN_INIT     = 32,
  parameter int DET_THR       = 1000,
  parameter int DET_COUNT     = 2,
  parameter int TARGET_EXP    = 14,
  parameter int HYST          = 2048,
  parameter int STEPS_PER_OCT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_i,
  input  logic [SAMPLE_W-1:0] s_q,
  input  logic                s_last,
  input  logic                s_preamble,
  input  logic                training_done,
  input  logic                restart,
  output logic [GAIN_W-1:0]   gain_code,
  output logic [1:0]          agc_mode
);
  localparam int ENERGY_W = 2 * SAMPLE_W + 1 + $clog2(MAX_SYM_LEN);
  localparam int POS_W    = $clog2(ENERGY_W);

  logic [ENERGY_W-1:0] energy;
  logic                e_valid, e_pre;
  logic [POS_W-1:0]    msb_pos;
  agc_mode_e           mode;

  assign s_ready  = 1'b1;
  assign agc_mode = mode;

  agc_energy_acc #(.SAMPLE_W(SAMPLE_W), .ENERGY_W(ENERGY_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clear(restart),
    .take(s_valid && s_ready), .last(s_last), .pre(s_preamble),
    .i_s(signed'(s_i)), .q_s(signed'(s_q)),
    .energy(energy), .e_valid(e_valid), .e_pre(e_pre)
  );

  agc_msb #(.W(ENERGY_W), .POS_W(POS_W)) msb_i (
    .value(energy), .pos(msb_pos)
  );

  agc_ctrl #(
    .GAIN_W(GAIN_W), .FINE_W(FINE_W), .GAIN_INIT(GAIN_INIT),
    .ENERGY_W(ENERGY_W), .POS_W(POS_W), .DET_THR(DET_THR),
    .DET_COUNT(DET_COUNT), .TARGET_EXP(TARGET_EXP), .HYST(HYST),
    .STEPS_PER_OCT(STEPS_PER_OCT)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .e_valid(e_valid), .e_pre(e_pre),
    .energy(energy), .msb_pos(msb_pos), .training_done(training_done),
    .restart(restart), .mode(mode), .gain(gain_code)
  );
endmodule

// File: rtl/agc_chk.sv
module agc_chk #(
  parameter int GAIN_W    = 6,
  parameter int FINE_W    = 2,
  parameter int GAIN_INIT = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              training_done,
  input logic              s_ready,
  input logic [GAIN_W-1:0] gain_code,
  input logic [1:0]        agc_mode
);
  logic [FINE_W-1:0] lo;
  assign lo = gain_code[FINE_W-1:0];

  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n) s_ready);

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    agc_mode != 2'b11);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (agc_mode == 2'b00 && gain_code == GAIN_W'(GAIN_INIT)));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_mode == 2'b01 && $past(agc_mode) == 2'b01) |-> $stable(gain_code));

  assert_train_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_mode == 2'b01 && training_done && !restart) |=> agc_mode == 2'b10);

  assert_fine_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_mode == 2'b10 && $past(agc_mode) == 2'b10)
      |-> $stable(gain_code[GAIN_W-1:FINE_W]));

  assert_fine_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_mode == 2'b10 && $past(agc_mode) == 2'b10)
      |-> (lo == $past(lo) || lo == FINE_W'($past(lo) + 1'b1)
           || lo == FINE_W'($past(lo) - 1'b1)));
endmodule

bind agc_top agc_chk #(.GAIN_W(GAIN_W), .FINE_W(FINE_W), .GAIN_INIT(GAIN_INIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .restart(restart), .training_done(training_done),
  .s_ready(s_ready), .gain_code(gain_code), .agc_mode(agc_mode)
);

// File: tb/agc_top_tb_top.sv
module agc_top_tb_top;
  localparam int GW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready, s_last = 1'b0, s_preamble = 1'b0;
  logic [7:0] s_i = '0, s_q = '0;
  logic training_done = 1'b0, restart = 1'b0;
  logic [GW-1:0] gain_code;
  logic [1:0] agc_mode;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  int m_mode = 0, m_gain = 32, m_cnt = 0;

  always #5 clk = ~clk;

  agc_top dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .s_last(s_last), .s_preamble(s_preamble),
    .training_done(training_done), .restart(restart),
    .gain_code(gain_code), .agc_mode(agc_mode)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int msb_of(input longint e);
    int p = 0;
    for (int k = 0; k < 40; k++) if (((e >> k) & 1) != 0) p = k;
    return p;
  endfunction

  function automatic void model(input longint e, input bit pre);
    if (m_mode == 0) begin
      if (e > 1000) begin
        if (m_cnt == 1) begin
          int g = m_gain + (14 - msb_of(e)) * 8;
          m_gain = (g < 0) ? 0 : (g > 63) ? 63 : g;
          m_mode = 1;
          m_cnt = 0;
        end else m_cnt++;
      end else m_cnt = 0;
    end else if (m_mode == 2 && pre) begin
      if (e < 14336 && (m_gain % 4) != 3) m_gain++;
      else if (e > 18432 && (m_gain % 4) != 0) m_gain--;
    end
  endfunction

  task automatic send_sym(input int len, input int a, input int b, input bit pre, input bit gaps);
    for (int k = 0; k < len; k++) begin
      if (gaps && (k % 3) == 1) begin
        @(negedge clk);
        s_valid = 1'b0; s_i = 8'h7f; s_q = 8'h81; s_last = 1'b1; s_preamble = ~pre;
      end
      @(negedge clk);
      s_valid = 1'b1; s_i = a[7:0]; s_q = b[7:0];
      s_last = (k == len - 1); s_preamble = pre;
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    repeat (3) @(negedge clk);
    model(longint'(len) * longint'(a * a + b * b), pre);
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    m_mode = 0; m_gain = 32; m_cnt = 0;
  endtask

  task automatic pulse_train();
    @(negedge clk); training_done = 1'b1;
    @(negedge clk); training_done = 1'b0;
    @(negedge clk);
    if (m_mode == 1) m_mode = 2;
  endtask

  task automatic check_state(input string tag);
    chk({tag, " mode"}, int'(agc_mode), m_mode);
    chk({tag, " gain"}, int'(gain_code), m_gain);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R2 reset");
    chk("R11 ready", int'(s_ready), 1);

    // R6: training_done in detect has no effect
    pulse_train();
    check_state("R6 ignored in detect");

    // R3: above, at-threshold, above keeps detecting
    send_sym(8, 20, 0, 1'b0, 1'b0);  check_state("R3 first above");
    send_sym(10, 10, 0, 1'b0, 1'b0); check_state("R3 at threshold clears run");
    send_sym(8, 20, 0, 1'b0, 1'b0);  check_state("R3 run restarted");
    send_sym(8, 20, 0, 1'b0, 1'b0);  check_state("R4 coarse after run");

    // R5: hold ignores symbols
    send_sym(8, 120, 0, 1'b1, 1'b0); check_state("R5 hold strong preamble");
    send_sym(8, 3, 0, 1'b1, 1'b0);   check_state("R5 hold weak preamble");
    pulse_train();
    check_state("R6 enter fine");

    // R7 increments to saturation, R9 non-preamble ignored
    send_sym(8, 40, 0, 1'b0, 1'b0);  check_state("R9 non-preamble low");
    for (int r = 0; r < 5; r++) begin
      send_sym(8, 40, 0, 1'b1, 1'b0); check_state("R7 low preamble step");
    end
    pulse_train();
    check_state("R6 ignored in fine");
    send_sym(14, 32, 0, 1'b1, 1'b0); check_state("R9 lower band edge");
    send_sym(18, 32, 0, 1'b1, 1'b0); check_state("R9 upper band edge");
    send_sym(8, 45, 0, 1'b1, 1'b0);  check_state("R9 in band");
    send_sym(8, 50, 0, 1'b0, 1'b0);  check_state("R9 non-preamble high");
    for (int r = 0; r < 5; r++) begin
      send_sym(8, 50, 0, 1'b1, 1'b0); check_state("R8 high preamble step");
    end

    // R10: restart from fine, discards partial symbol
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); s_valid = 1'b1; s_i = 8'd127; s_q = 8'd127; s_last = 1'b0;
    end
    @(negedge clk); s_valid = 1'b0;
    pulse_restart();
    check_state("R10 restart state");
    send_sym(8, 10, 0, 1'b0, 1'b0);  check_state("R10 partial discarded");
    send_sym(8, 20, 0, 1'b0, 1'b0);  check_state("R10 run count cleared");

    // R4/R1 sweep of coarse setting, with and without idle junk beats
    for (int a = 12; a < 128; a += 5) begin
      for (int mix = 0; mix < 2; mix++) begin
        pulse_restart();
        send_sym(8, a, mix ? -(a / 2) : 0, 1'b0, mix == 1);
        send_sym(8, a, mix ? -(a / 2) : 0, 1'b0, mix == 1);
        check_state(mix ? "R1 sweep with gaps" : "R4 sweep");
      end
    end
    for (int len = 8; len <= 32; len += 8) begin
      pulse_restart();
      send_sym(len, 127, 127, 1'b0, 1'b1);
      send_sym(len, 127, 127, 1'b0, 1'b1);
      check_state("R4 low clamp sweep");
    end
    pulse_restart();
    send_sym(8, 12, 0, 1'b0, 1'b0);
    send_sym(8, 12, 0, 1'b0, 1'b0);
    check_state("R4 high clamp");
    chk("R11 ready end", int'(s_ready), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule